// File: doc/BRIEF.md
# Dual Accumulator Multiply-Accumulate Unit

This block is a multiply-accumulate engine with two accumulators. Each accumulator holds a 56-bit signed quantity inside a 64-bit register. Each start strobe carries an operation code, an accumulator select and two 32-bit operands. The engine forms a product with an operation-specific alignment and then loads, adds or subtracts it into the target accumulator. After every arithmetic update the result is folded back into 56 bits by sign extension. A separate combine operation adds accumulator 1, arithmetically shifted right by 16, into accumulator 0.

A single operation is accepted per cycle and issue can run back to back. Each operation is committed at the clock edge that samples its strobe. A one-cycle done pulse follows at the same time. Both accumulator values are always visible on the outputs.

Top module: `dual_acc_mac`

## Requirements
- R1: After the asynchronous active-low reset, both accumulator outputs are zero and done is low.
- R2: done_o is high for exactly the one cycle that follows each cycle in which start_i is sampled high. The accumulator outputs change only at the edge that samples start_i high.
- R3: Code 0 (word-by-unsigned-half multiply-add): the sign-extended operand A times the zero-extended low 16 bits of operand B is added to accumulator 1. The sum is then sign-extended from bit 55. Accumulator 0 is unchanged.
- R4: Code 1 (word-by-unsigned-half multiply-load): accumulator 1 is replaced by the same product, sign-extended from bit 47. Accumulator 0 is unchanged.
- R5: Code 2 (low-half multiply-subtract): the signed low halves of A and B are multiplied into a 32-bit product. That product is sign-extended, shifted left by 16 and subtracted from the selected accumulator (select 0 picks accumulator 0, select 1 picks accumulator 1). The result is sign-extended from bit 55. The other accumulator is unchanged.
- R6: Code 3 (low-by-high multiply-add): the signed low half of A times the signed high half of B gives a 32-bit product. That product is sign-extended, shifted left by 16 and added to accumulator 1. The result is sign-extended from bit 55. Accumulator 0 is unchanged.
- R7: Code 4 (combine): accumulator 0 becomes accumulator 0 plus accumulator 1 shifted arithmetically right by 16, as a full 64-bit sum without folding. Accumulator 1 is unchanged.
- R8: Codes 5, 6 and 7 leave both accumulators unchanged but still produce the done pulse.
- R9: The accumulator select input has no effect on any code other than 2.
- R10: Repeated accumulation that overflows 56 bits wraps modulo 2^56, so the result always equals the sign extension of its low 56 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (0 to 4 defined) |
| acc_sel_i | input | 1 | Target accumulator for code 2 |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| acc0_o | output | 64 | Accumulator 0 |
| acc1_o | output | 64 | Accumulator 1 |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every result is due one cycle after its strobe. The done pulse and both accumulator values are registered at the edge that samples start_i. The driver applies each operation on a falling edge and pushes the expected pair of accumulators into a queue. The monitor samples on the next falling edge, when done_o must be high, and compares both outputs against the head of the queue. A done pulse with an empty queue, or a queue still holding items at the end, counts as a failure. The result is therefore checked in its own cycle and not one cycle early or late.

// File: rtl/dual_acc_mac_pkg.sv
package dual_acc_mac_pkg;
  localparam int DATA_W     = 32;
  localparam int HALF_W     = 16;
  localparam int ACC_W      = 64;
  localparam int KEEP_W     = 56;
  localparam int MUL_KEEP_W = 48;
  localparam int N_ACC      = 2;
  localparam int OP_W       = 3;

  typedef enum logic [OP_W-1:0] {
    OP_MAC_WU = 3'd0,
    OP_MUL_WU = 3'd1,
    OP_MSB_LO = 3'd2,
    OP_MAC_LH = 3'd3,
    OP_SADD   = 3'd4
  } mac_op_e;

  typedef enum logic [1:0] {
    UPD_ADD,
    UPD_SUB,
    UPD_LOAD
  } upd_mode_e;

  typedef enum logic [1:0] {
    WRAP_KEEP,
    WRAP_MUL,
    WRAP_NONE
  } wrap_e;

  // copy bit w-1 into every bit above it
  function automatic logic [ACC_W-1:0] sext_from(input logic [ACC_W-1:0] v,
                                                 input int unsigned w);
    logic [ACC_W-1:0] r;
    r = v;
    for (int i = 0; i < ACC_W; i++) begin
      if (i >= int'(w)) r[i] = v[w-1];
    end
    return r;
  endfunction
endpackage

// File: rtl/dam_decode.sv
module dam_decode
  import dual_acc_mac_pkg::*;
(
  input  mac_op_e          op_i,
  input  logic             sel_i,
  output logic [N_ACC-1:0] hit_o,
  output upd_mode_e        mode_o,
  output wrap_e            wrap_o
);
  always_comb begin
    hit_o  = '0;
    mode_o = UPD_ADD;
    wrap_o = WRAP_KEEP;
    unique case (op_i)
      OP_MAC_WU: hit_o[1] = 1'b1;
      OP_MUL_WU: begin
        hit_o[1] = 1'b1;
        mode_o   = UPD_LOAD;
        wrap_o   = WRAP_MUL;
      end
      OP_MSB_LO: begin
        hit_o[sel_i] = 1'b1;
        mode_o       = UPD_SUB;
      end
      OP_MAC_LH: hit_o[1] = 1'b1;
      OP_SADD: begin
        hit_o[0] = 1'b1;
        wrap_o   = WRAP_NONE;
      end
      default: hit_o = '0;
    endcase
  end
endmodule

// File: rtl/dam_term.sv
module dam_term
  import dual_acc_mac_pkg::*;
(
  input  mac_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [ACC_W-1:0]  acc1_i,
  output logic [ACC_W-1:0]  term_o
);
  localparam int PAD_W = ACC_W - 2*HALF_W - HALF_W;

  logic signed [ACC_W-1:0]    a_sx, b_zx, wu_prod;
  logic signed [HALF_W-1:0]   a_lo, b_lo, b_hi;
  logic signed [2*HALF_W-1:0] lo_prod, lh_prod;
  logic [ACC_W-1:0]           lo_term, lh_term, sadd_term;

  assign a_sx    = {{(ACC_W-DATA_W){a_i[DATA_W-1]}}, a_i};
  assign b_zx    = {{(ACC_W-HALF_W){1'b0}}, b_i[HALF_W-1:0]};
  assign wu_prod = a_sx * b_zx;

  assign a_lo    = a_i[HALF_W-1:0];
  assign b_lo    = b_i[HALF_W-1:0];
  assign b_hi    = b_i[DATA_W-1:HALF_W];
  assign lo_prod = a_lo * b_lo;
  assign lh_prod = a_lo * b_hi;

  // 32-bit product, sign-extended and aligned up by one half-word
  assign lo_term   = {{PAD_W{lo_prod[2*HALF_W-1]}}, lo_prod, {HALF_W{1'b0}}};
  assign lh_term   = {{PAD_W{lh_prod[2*HALF_W-1]}}, lh_prod, {HALF_W{1'b0}}};
  assign sadd_term = $signed(acc1_i) >>> HALF_W;

  always_comb begin
    unique case (op_i)
      OP_MAC_WU, OP_MUL_WU: term_o = wu_prod;
      OP_MSB_LO:            term_o = lo_term;
      OP_MAC_LH:            term_o = lh_term;
      OP_SADD:              term_o = sadd_term;
      default:              term_o = '0;
    endcase
  end
endmodule

// File: rtl/dam_lane.sv
module dam_lane
  import dual_acc_mac_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [N_ACC-1:0] hit_i,
  input  upd_mode_e        mode_i,
  input  wrap_e            wrap_i,
  input  logic [ACC_W-1:0] term_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q, raw, nxt;

  always_comb begin
    unique case (mode_i)
      UPD_SUB:  raw = acc_q - term_i;
      UPD_LOAD: raw = term_i;
      default:  raw = acc_q + term_i;
    endcase
    unique case (wrap_i)
      WRAP_KEEP: nxt = sext_from(raw, KEEP_W);
      WRAP_MUL:  nxt = sext_from(raw, MUL_KEEP_W);
      default:   nxt = raw;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    acc_q <= '0;
    else if (start_i && hit_i[IDX]) acc_q <= nxt;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/dual_acc_mac.sv
module dual_acc_mac
  import dual_acc_mac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              acc_sel_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [ACC_W-1:0]  acc0_o,
  output logic [ACC_W-1:0]  acc1_o,
  output logic              done_o
);
  mac_op_e          op;
  logic [N_ACC-1:0] hit;
  upd_mode_e        mode;
  wrap_e            wrap;
  logic [ACC_W-1:0] term;
  logic [ACC_W-1:0] acc [N_ACC];
  logic             done_q;

  assign op = mac_op_e'(op_i);

  dam_decode u_decode (
    .op_i  (op),
    .sel_i (acc_sel_i),
    .hit_o (hit),
    .mode_o(mode),
    .wrap_o(wrap)
  );

  dam_term u_term (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .acc1_i(acc[1]),
    .term_o(term)
  );

  for (genvar g = 0; g < N_ACC; g++) begin : g_lane
    dam_lane #(.IDX(g)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start_i),
      .hit_i  (hit),
      .mode_i (mode),
      .wrap_i (wrap),
      .term_i (term),
      .acc_o  (acc[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= start_i;
  end

  assign acc0_o = acc[0];
  assign acc1_o = acc[1];
  assign done_o = done_q;
endmodule

// File: rtl/dam_checker.sv
module dam_checker
  import dual_acc_mac_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [OP_W-1:0]   op_i,
  input logic              acc_sel_i,
  input logic [ACC_W-1:0]  acc0_o,
  input logic [ACC_W-1:0]  acc1_o,
  input logic              done_o
);
  assert_done_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  assert_done_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!done_o && $stable(acc0_o) && $stable(acc1_o)));
  assert_acc0_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (op_i == OP_MAC_WU || op_i == OP_MAC_LH || op_i == OP_MUL_WU))
    |=> $stable(acc0_o));
  assert_mul_fold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_MUL_WU)
    |=> (acc1_o[ACC_W-1:MUL_KEEP_W-1] == '0 || acc1_o[ACC_W-1:MUL_KEEP_W-1] == '1));
  assert_sub_other_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_MSB_LO) |=> (acc_sel_i ? 1'b1 : 1'b1) &&
    ($past(acc_sel_i) ? $stable(acc0_o) : $stable(acc1_o)));
  assert_sadd_acc1_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_SADD) |=> $stable(acc1_o));
  assert_bad_op_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i > OP_SADD) |=> ($stable(acc0_o) && $stable(acc1_o) && done_o));
  assert_fold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (op_i == OP_MAC_WU || op_i == OP_MAC_LH || (op_i == OP_MSB_LO && acc_sel_i)))
    |=> (acc1_o[ACC_W-1:KEEP_W-1] == '0 || acc1_o[ACC_W-1:KEEP_W-1] == '1));
endmodule

bind dual_acc_mac dam_checker u_chk (.*);

// File: tb/dual_acc_mac_test.sv
module dual_acc_mac_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic        sel = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [63:0] acc0, acc1;
  logic        done;

  int checks = 0;
  int errors = 0;
  longint m0 = 0, m1 = 0;

  typedef struct packed {
    logic [63:0] e0;
    logic [63:0] e1;
    logic [7:0]  req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  dual_acc_mac uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .acc_sel_i(sel),
    .a_i(a), .b_i(b), .acc0_o(acc0), .acc1_o(acc1), .done_o(done)
  );

  function automatic longint fold(longint v, int msb);
    longint s;
    s = v <<< (63 - msb);
    return s >>> (63 - msb);
  endfunction

  function automatic longint wu_prod(logic [31:0] x, logic [31:0] y);
    longint sx, uy;
    sx = longint'(int'(x));
    uy = longint'({48'd0, y[15:0]});
    return sx * uy;
  endfunction

  task automatic check(input bit ok, input int req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  // call on a falling edge; returns on the next falling edge
  task automatic issue(input logic [2:0] o, input logic s, input logic [31:0] x,
                       input logic [31:0] y, input int req);
    int p;
    exp_t e;
    case (o)
      3'd0: m1 = fold(m1 + wu_prod(x, y), 55);
      3'd1: m1 = fold(wu_prod(x, y), 47);
      3'd2: begin
        p = int'(shortint'(x[15:0])) * int'(shortint'(y[15:0]));
        if (s) m1 = fold(m1 - longint'(p) * 64'sd65536, 55);
        else   m0 = fold(m0 - longint'(p) * 64'sd65536, 55);
      end
      3'd3: begin
        p = int'(shortint'(x[15:0])) * int'(shortint'(y[31:16]));
        m1 = fold(m1 + longint'(p) * 64'sd65536, 55);
      end
      3'd4: m0 = m0 + (m1 >>> 16);
      default: ;
    endcase
    e.e0 = m0; e.e1 = m1; e.req = 8'(req);
    sb.push_back(e);
    start = 1'b1; op = o; sel = s; a = x; b = y;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      if (sb.size() == 0) begin
        check(1'b0, 2, {63'd0, done}, 64'd0); // R2 spurious done
      end else begin
        e = sb.pop_front();
        check(acc0 == e.e0, int'(e.req), acc0, e.e0);
        check(acc1 == e.e1, int'(e.req), acc1, e.e1);
      end
    end
  end

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h8000_0000;
      1: return 32'h8000_8000;
      2: return 32'h7FFF_7FFF;
      3: return 32'hFFFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(acc0 == 64'd0, 1, acc0, 64'd0);
    check(acc1 == 64'd0, 1, acc1, 64'd0);
    check(done == 1'b0, 1, {63'd0, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(3'd1, 0, 32'h8000_0000, 32'h0000_FFFF, 4);  // R4 extreme
    issue(3'd1, 1, 32'h7FFF_FFFF, 32'h1234_8000, 4);  // R4, R9 sel ignored
    issue(3'd0, 0, 32'h8000_0000, 32'hABCD_FFFF, 3);  // R3, R9
    issue(3'd0, 1, 32'h0001_2345, 32'h0000_0007, 3);  // R3
    issue(3'd2, 0, 32'h0000_8000, 32'h0000_8000, 5);  // R5 -32768 squared into acc0
    issue(3'd2, 1, 32'h0000_8000, 32'h0000_7FFF, 5);  // R5 into acc1
    issue(3'd3, 0, 32'h0000_8000, 32'h8000_0000, 6);  // R6
    issue(3'd3, 1, 32'h1234_7FFF, 32'h7FFF_1111, 6);  // R6, R9
    issue(3'd4, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 7);  // R7, R9
    issue(3'd5, 0, 32'h8000_0000, 32'h0000_FFFF, 8);  // R8
    issue(3'd6, 1, 32'h8000_0000, 32'h0000_FFFF, 8);  // R8
    issue(3'd7, 0, 32'h1111_1111, 32'h2222_2222, 8);  // R8
    idle(5);
    // R2 no change while idle
    check(acc0 == m0, 2, acc0, m0);
    check(acc1 == m1, 2, acc1, m1);
    check(done == 1'b0, 2, {63'd0, done}, 64'd0);

    for (int i = 0; i < 60; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      issue(o, 1'($urandom), pick(), pick(), (o > 3'd4) ? 8 : int'(o) + 3);
    end
    idle(2);

    // R10 drive acc1 past the 56-bit range
    issue(3'd1, 0, 32'h8000_0000, 32'h0000_FFFF, 10);
    for (int i = 0; i < 300; i++) issue(3'd0, 0, 32'h8000_0000, 32'h0000_FFFF, 10);
    issue(3'd4, 0, 32'd0, 32'd0, 7);
    idle(3);

    check(sb.size() == 0, 2, 64'(sb.size()), 64'd0); // R2 every op produced done
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule